// File: doc/BRIEF.md
# Orthogonal Latin Square Double-Error-Correcting Check Generator

This block computes the check bits for a 16-bit data word protected by an Orthogonal Latin Square code of block order 4 that corrects two errors. The data word is treated as a 4×4 grid of bits. Each check bit is the even parity of a set of four grid cells. One group of checks covers the grid rows and one covers the columns. Each of the remaining groups covers the cells that share a symbol in one of two mutually orthogonal Latin squares.

Because the check sets come from rows, columns and orthogonal squares, any two data bits share at most one check. Each data bit sits in exactly 2t checks. A majority-logic decoder placed downstream relies on both of these properties. The block emits the check bits on their own and also as a codeword with the checks above the data.

A parameter chooses between two output forms. One is a purely combinational output. The other is a registered output with one cycle of latency, which loads only when a valid strobe is asserted. A second parameter sets the correction strength t to 1 or 2, which gives 8 or 16 check bits.

Top module: `ols_encoder`

## Requirements
- R1: `out_word` is the concatenation {check bits, data}: bits [15:0] carry the data word and the bits above carry `out_check`.
- R2: The data bit at grid row r and column c is `in_data[4*r+c]`. For each row r in 0..3, check bit r is the XOR of the four data bits in row r.
- R3: For each column c in 0..3, check bit 4+c is the XOR of the four data bits in column c.
- R4: Check bit 8+s is the XOR of the cells where r XOR c equals s. This is addition over GF(4) with elements 0..3.
- R5: Check bit 12+s is the XOR of the cells where (2·r) XOR c equals s. Multiplication is over GF(4) with x² = x+1, so 2·r maps 0,1,2,3 to 0,2,3,1. This group exists only when T = 2.
- R6: Each data bit takes part in exactly 2·T checks, so a one-hot data word gives a check word of weight 2·T. Any two distinct data bits share at most one check. Every check covers exactly four bits, so all-ones data gives an all-zero check word.
- R7: With REG_OUT = 1, a word presented with `in_valid` high appears on `out_check` and `out_word` after the next rising clock edge, and `out_valid` is high in that cycle.
- R8: With REG_OUT = 1, a cycle with `in_valid` low leaves `out_check` and `out_word` unchanged and drives `out_valid` low after the edge, whatever `in_data` holds.
- R9: With REG_OUT = 1, while `rst_n` is low, `out_valid`, `out_check` and `out_word` are all zero.
- R10: With REG_OUT = 0, the outputs follow the inputs in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output form |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as a word to encode |
| in_data | input | 16 | Data word, bit 4*r+c is grid cell (r,c) |
| out_valid | output | 1 | Marks the outputs as holding an encoded word |
| out_check | output | 8*T | Check bits, in groups of four: rows, columns, square 1, square 2 |
| out_word | output | 8*T+16 | Codeword {out_check, data} |

## Verification
The bench builds two copies of the block, both with T = 2, so all four check groups are present, including the GF(4)-multiplied square. One copy uses REG_OUT = 1 and the other uses REG_OUT = 0. Both copies see the same stimulus. This lets the same vectors confirm the one-cycle latency, the hold-on-invalid behaviour and the reset values of the registered form, and the zero-latency pass-through of the combinational form. Running all 120 two-hot words exposes the "at most one shared check" property, which single-bit walking patterns alone cannot reveal.

// File: rtl/ols_pkg.sv
package ols_pkg;

    // The grid order is fixed by the GF(4) arithmetic used for the squares.
    localparam int unsigned ORDER  = 4;
    localparam int unsigned DATA_W = ORDER * ORDER;
    localparam int unsigned SYM_W  = $clog2(ORDER);

    // GF(4) product, elements are 2-bit polynomials in x with x^2 = x + 1.
    function automatic logic [SYM_W-1:0] gf4_mul(input logic [SYM_W-1:0] a,
                                                 input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        acc = '0;
        if (a[0]) acc = acc ^ b;
        if (a[1]) acc = acc ^ {b[1] ^ b[0], b[1]};
        return acc;
    endfunction

    // Symbol of cell (r,c) in the check group: 0 rows, 1 columns,
    // group g >= 2 uses the square (g-1)*r + c over GF(4).
    function automatic logic [SYM_W-1:0] cell_symbol(input int unsigned grp,
                                                     input int unsigned r,
                                                     input int unsigned c);
        logic [SYM_W-1:0] rs;
        logic [SYM_W-1:0] cs;
        logic [SYM_W-1:0] gs;
        rs = SYM_W'(r);
        cs = SYM_W'(c);
        gs = SYM_W'(grp - 1);
        if (grp == 0)      return rs;
        else if (grp == 1) return cs;
        else               return gf4_mul(gs, rs) ^ cs;
    endfunction

    // Data bits covered by check s of group grp.
    function automatic logic [DATA_W-1:0] cover_mask(input int unsigned grp,
                                                     input int unsigned s);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned r = 0; r < ORDER; r++) begin
            for (int unsigned c = 0; c < ORDER; c++) begin
                if (cell_symbol(grp, r, c) == SYM_W'(s))
                    m[r*ORDER + c] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ols_check_group.sv
module ols_check_group
    import ols_pkg::*;
#(
    parameter int unsigned GROUP = 0
) (
    input  logic [DATA_W-1:0] data,
    output logic [ORDER-1:0]  chk
);

    for (genvar s = 0; s < ORDER; s++) begin : g_sym
        localparam logic [DATA_W-1:0] MASK = cover_mask(GROUP, s);
        assign chk[s] = ^(data & MASK);
    end

endmodule

// File: rtl/ols_out_stage.sv
module ols_out_stage #(
    parameter int unsigned CW      = 16,
    parameter int unsigned DW      = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_chk,
    input  logic [DW-1:0] in_dat,
    output logic          out_valid,
    output logic [CW-1:0] out_chk,
    output logic [DW-1:0] out_dat
);

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] chk;
        logic [DW-1:0] dat;
    } stage_t;

    if (REG_OUT) begin : g_reg
        stage_t st_d;
        stage_t st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.chk = in_chk;
                st_d.dat = in_dat;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_valid = st_q.valid;
        assign out_chk   = st_q.chk;
        assign out_dat   = st_q.dat;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign out_valid = in_valid;
        assign out_chk   = in_chk;
        assign out_dat   = in_dat;
    end

endmodule

// File: rtl/ols_encoder.sv
module ols_encoder
    import ols_pkg::*;
#(
    parameter int unsigned T       = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [ols_pkg::DATA_W-1:0]        in_data,
    output logic                              out_valid,
    output logic [2*T*ols_pkg::ORDER-1:0]     out_check,
    output logic [2*T*ols_pkg::ORDER+ols_pkg::DATA_W-1:0] out_word
);

    localparam int unsigned GROUPS = 2 * T;
    localparam int unsigned CHK_W  = GROUPS * ORDER;

    logic [CHK_W-1:0]  chk_comb;
    logic [DATA_W-1:0] dat_out;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ols_check_group #(.GROUP(g)) u_grp (
            .data (in_data),
            .chk  (chk_comb[g*ORDER +: ORDER])
        );
    end

    ols_out_stage #(.CW(CHK_W), .DW(DATA_W), .REG_OUT(REG_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_chk   (chk_comb),
        .in_dat   (in_data),
        .out_valid(out_valid),
        .out_chk  (out_check),
        .out_dat  (dat_out)
    );

    assign out_word = {out_check, dat_out};

endmodule

// File: rtl/ols_encoder_chk.sv
module ols_encoder_chk #(
    parameter int unsigned T       = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [15:0]                in_data,
    input logic                       out_valid,
    input logic [8*T-1:0]             out_check,
    input logic [8*T+15:0]            out_word
);

    // R6: one-hot data sets exactly 2T checks
    assert_onehot_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_word[15:0]) == 1) |-> ($countones(out_check) == 2*T));

    // R6: two data bits share at most one check
    assert_pair_share_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_word[15:0]) == 2) |-> ($countones(out_check) >= 4*T-2));

    // R6: all-ones data gives zero checks
    assert_allones_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_word[15:0])) |-> (out_check == '0));

    if (REG_OUT) begin : g_reg_chk
        // R7: one cycle of latency
        assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && out_word[15:0] == $past(in_data)));

        // R8: hold while invalid
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_word)));
    end else begin : g_comb_chk
        // R10: same-cycle pass-through
        assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid == in_valid) && (out_word[15:0] == in_data));
    end

endmodule

bind ols_encoder ols_encoder_chk #(.T(T), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_check(out_check),
    .out_word (out_word)
);

// File: tb/tb_ols_encoder.sv
module tb_ols_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        r_valid, c_valid;
    logic [15:0] r_check, c_check;
    logic [31:0] r_word, c_word;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ols_encoder #(.T(2), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(r_valid), .out_check(r_check), .out_word(r_word));

    ols_encoder #(.T(2), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(c_valid), .out_check(c_check), .out_word(c_word));

    // Software model of the parity sets.
    function automatic logic [15:0] model(input logic [15:0] d);
        int dbl [4] = '{0, 2, 3, 1};
        logic [15:0] p = '0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                if (d[4*r+c]) begin
                    p[r]                 = ~p[r];
                    p[4+c]               = ~p[4+c];
                    p[8+(r ^ c)]         = ~p[8+(r ^ c)];
                    p[12+(dbl[r] ^ c)]   = ~p[12+(dbl[r] ^ c)];
                end
            end
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one word, check comb copy at once and registered copy after the edge.
    task automatic apply(input logic [15:0] w, input bit groups);
        logic [15:0] e;
        e = model(w);
        in_data  = w;
        in_valid = 1'b1;
        #1;
        check("R10 comb word", c_word, {e, w});
        check("R10 comb valid", 32'(c_valid), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 reg valid", 32'(r_valid), 32'd1);
        check("R1 reg word", r_word, {e, w});
        if (groups) begin
            check("R2 rows",    32'(r_check[3:0]),   32'(e[3:0]));
            check("R3 columns", 32'(r_check[7:4]),   32'(e[7:4]));
            check("R4 square1", 32'(r_check[11:8]),  32'(e[11:8]));
            check("R5 square2", 32'(r_check[15:12]), 32'(e[15:12]));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = 16'hA5C3;
        repeat (3) @(negedge clk);
        check("R9 reset valid", 32'(r_valid), 32'd0);
        check("R9 reset word", r_word, 32'd0);
        check("R10 comb idle valid", 32'(c_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_extremes();
        apply(16'h0000, 1'b1);
        check("R6 zero checks", 32'(r_check), 32'd0);
        apply(16'hFFFF, 1'b1);
        check("R6 all-ones checks", 32'(r_check), 32'd0);
    endtask

    task automatic t_walk();
        for (int i = 0; i < 16; i++) begin
            apply(16'(1) << i, 1'b1);
            check("R6 single weight", 32'($countones(r_check)), 32'd4);
        end
    endtask

    task automatic t_pairs();
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                apply((16'(1) << i) | (16'(1) << j), 1'b0);
                check("R6 pair shares <=1", 32'($countones(r_check) >= 6), 32'd1);
            end
        end
    endtask

    task automatic t_patterns();
        apply(16'h1234, 1'b1);
        apply(16'hBEEF, 1'b1);
        apply(16'h0F0F, 1'b1);
        apply(16'h8421, 1'b1);
    endtask

    task automatic t_hold();
        logic [15:0] a;
        a = 16'h3C5A;
        apply(a, 1'b0);
        in_data = 16'hFFFE;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 hold word", r_word, {model(a), a});
            check("R8 hold valid low", 32'(r_valid), 32'd0);
            #1;
            check("R10 comb follows", c_word, {model(16'hFFFE), 16'hFFFE});
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_extremes();
        t_walk();
        t_pairs();
        t_patterns();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule